// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Tracker

This block sits beside the command scheduler of an SDRAM controller. It watches each command as it is issued: a command code, a bank number and an auto-precharge flag. It keeps one state machine per bank, which moves a bank through idle, open, write burst with auto precharge, write recovery and precharging. The scheduler uses the per-bank flags to decide what it may issue next. The data path uses the write-accept strobe to know when to drive a write beat, and the read-valid strobe to know when to capture returning read data.

The block handles concurrent auto precharge. A write with auto precharge can be cut short by a read or a write to another bank. When that happens, the interrupted bank starts its write-recovery time on the edge that registers the interrupting command, then precharges, then becomes idle. It does not wait for the burst's nominal end. Recovery and precharge times, burst length and CAS latency are parameters given in clock cycles. The defaults are 2 cycles of recovery, 3 cycles of precharge, a burst of 4 and a CAS latency of 3.

Top module: `sdram_ap_tracker`

## Requirements
- R1: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, and codes 5 to 7 act as NOP. An ACTIVE to an idle bank opens it, so `bank_open` for that bank reads 1 after the edge. After reset every bank is idle, all `bank_ready` bits are 1, and every other output is 0.
- R2: A WRITE registered at edge k raises `wr_accept` in the cycle of the command and in the BL-1 cycles that follow. It is 0 after that unless another write arrives.
- R3: A READ to another bank during a running write burst ends that burst. `wr_accept` is 0 from the cycle of the READ onward, so the last beat of the old burst is the one registered one edge before the READ.
- R4: A WRITE to another bank during a running write burst ends the old burst and starts a new burst of BL beats. `wr_accept` stays 1 in the cycle of the new WRITE and in the BL-1 cycles after it.
- R5: A bank whose write with auto precharge is interrupted at edge k shows `bank_recov` for TDPL cycles starting after edge k. It then shows `bank_prech` for TRP cycles, then `bank_ready`.
- R6: An uninterrupted write with auto precharge registered at edge k enters recovery after edge k+BL. It then follows the same TDPL, TRP and ready sequence.
- R7: A READ registered at edge k raises `rd_valid` for BL cycles, first visible after edge k+CL-1, so that the data is captured at edges k+CL through k+CL+BL-1.
- R8: ACTIVE is legal only to an idle bank. READ, WRITE and PRECHARGE are legal only to an open bank. Any other command (other than NOP) raises `proto_err` for one cycle after its edge. It changes no bank state, gives no write beat and starts no read data.
- R9: A bank becomes ready on the edge its precharge time ends, and an ACTIVE issued in that first ready cycle is accepted.
- R10: A READ with auto precharge registered at edge k keeps the bank busy until edge k+BL. The bank then shows `bank_prech` for TRP cycles and becomes ready.
- R11: A PRECHARGE to an open bank registered at edge k shows `bank_prech` for TRP cycles, then `bank_ready`.
- R12: A WRITE without auto precharge leaves its bank open after the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 3 | Command issued this cycle (encoding in R1) |
| cmd_bank | input | $clog2(NB) | Bank addressed by the command |
| cmd_ap | input | 1 | Auto-precharge flag for READ and WRITE |
| bank_ready | output | NB | Bank is idle and can take ACTIVE |
| bank_open | output | NB | Bank is open and takes READ, WRITE, PRECHARGE |
| bank_recov | output | NB | Bank is in write recovery |
| bank_prech | output | NB | Bank is precharging |
| wr_accept | output | 1 | Write data beat is taken this cycle |
| rd_valid | output | 1 | Read data beat is valid this cycle |
| proto_err | output | 1 | The previous command was illegal for its bank |

## Verification
A bank whose counter or state is wrong shows up at the ports at once. Its recovery, precharge or ready flag changes one or more edges away from the expected one. Its flags are compared after every edge of each scenario, so a timing error of one cycle is caught in that cycle. A wrong write-burst count shows up as `wr_accept` being high or low in the wrong cycle, at or right after the interrupting command. A wrong read pipeline moves the `rd_valid` window, which is checked edge by edge up to CL+BL cycles after the READ.

// File: rtl/sdram_ap_pkg.sv
package sdram_ap_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_OPEN,
    BK_WRAP,
    BK_RDAP,
    BK_RECOV,
    BK_PRECH
  } bank_st_e;

  // width of a down-counter able to hold the largest of three cycle counts
  function automatic int cnt_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // which commands a bank accepts in a given state
  function automatic logic cmd_allowed(input cmd_e c, input bank_st_e s);
    case (c)
      CMD_ACT:                  return s == BK_IDLE;
      CMD_RD, CMD_WR, CMD_PRE:  return s == BK_OPEN;
      default:                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst #(
  parameter int BL = 4,
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_go,
  input  logic rd_go,
  output logic burst_idle,
  output logic intr_go,
  output logic wr_accept
);

  logic [CW-1:0] beats_left;

  assign burst_idle = (beats_left == '0);
  // a legal read or write while beats remain cuts the running burst
  assign intr_go    = (rd_go || wr_go) && !burst_idle;
  // beat in the command cycle of a write, or in a running burst not cut by a read
  assign wr_accept  = wr_go || (!burst_idle && !rd_go);

  always_ff @(posedge clk) begin
    if (!rst_n)
      beats_left <= '0;
    else if (wr_go)
      beats_left <= CW'(BL - 1);
    else if (rd_go)
      beats_left <= '0;
    else if (!burst_idle)
      beats_left <= beats_left - 1'b1;
  end

  // R3
  // a read (with no write) leaves no beat in the next cycle unless a new write comes
  rd_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !wr_go) |=> (wr_accept == wr_go));

  // R2
  // a write always leaves beats pending in the next cycle when BL exceeds one
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && BL > 1) |=> !burst_idle);

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int CL = 3,
  parameter int BL = 4,
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  output logic rd_valid
);

  localparam int PD = (CL < 2) ? 1 : CL - 1;

  logic [PD-1:0] lat_pipe;
  logic [CW-1:0] rd_left;
  logic          launch;

  initial begin
    if (CL < 2) $error("sdram_rd_pipe: CL must be at least 2");
  end

  assign launch   = lat_pipe[PD-1];
  assign rd_valid = (rd_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_pipe <= '0;
      rd_left  <= '0;
    end else begin
      lat_pipe[0] <= rd_go;
      for (int i = 1; i < PD; i++) lat_pipe[i] <= lat_pipe[i-1];
      if (launch)
        rd_left <= CW'(BL);
      else if (rd_valid)
        rd_left <= rd_left - 1'b1;
    end
  end

  // R7
  // read data becomes valid only after a read has travelled the latency pipe
  rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rd_valid)) |-> $past(launch));

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_ap_pkg::*;
#(
  parameter int BL   = 4,
  parameter int TDPL = 2,
  parameter int TRP  = 3,
  parameter int CW   = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_go,
  input  logic     rd_go,
  input  logic     wr_go,
  input  logic     pre_go,
  input  logic     ap,
  input  logic     burst_idle,
  input  logic     intr_go,
  output bank_st_e st
);

  logic [CW-1:0] cnt;
  logic          cnt_zero;
  logic          rec_start;
  logic          pre_start;
  logic          to_idle;

  assign cnt_zero  = (cnt == '0);
  // recovery starts when the burst ends naturally or is cut by another bank
  assign rec_start = (st == BK_WRAP) && (burst_idle || intr_go);
  assign pre_start = ((st == BK_RECOV) || (st == BK_RDAP)) && cnt_zero;
  assign to_idle   = (st == BK_PRECH) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        BK_IDLE: if (act_go) st <= BK_OPEN;
        BK_OPEN: begin
          if (rd_go && ap) begin
            st  <= BK_RDAP;
            cnt <= CW'(BL - 1);
          end else if (wr_go && ap) begin
            st  <= BK_WRAP;
          end else if (pre_go) begin
            st  <= BK_PRECH;
            cnt <= CW'(TRP - 1);
          end
        end
        BK_WRAP: if (rec_start) begin
          st  <= BK_RECOV;
          cnt <= CW'(TDPL - 1);
        end
        BK_RDAP, BK_RECOV: begin
          if (pre_start) begin
            st  <= BK_PRECH;
            cnt <= CW'(TRP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_PRECH: begin
          if (to_idle) st <= BK_IDLE;
          else         cnt <= cnt - 1'b1;
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  // R5
  // recovery is entered only from a write burst with auto precharge
  recov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_RECOV && $past(st) != BK_RECOV) |-> $past(st) == BK_WRAP);

  // R9
  // a bank returns to idle only from precharging
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_IDLE && $past(st) != BK_IDLE) |-> $past(st) == BK_PRECH);

  // R11
  // precharging is reached only from open, recovery or a read burst with auto precharge
  prech_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_PRECH && $past(st) != BK_PRECH) |->
      ($past(st) == BK_OPEN || $past(st) == BK_RECOV || $past(st) == BK_RDAP));

endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_ap_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BL   = 4,
  parameter int CL   = 3,
  parameter int TDPL = 2,
  parameter int TRP  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            cmd_code,
  input  logic [$clog2(NB)-1:0] cmd_bank,
  input  logic                  cmd_ap,
  output logic [NB-1:0]         bank_ready,
  output logic [NB-1:0]         bank_open,
  output logic [NB-1:0]         bank_recov,
  output logic [NB-1:0]         bank_prech,
  output logic                  wr_accept,
  output logic                  rd_valid,
  output logic                  proto_err
);

  localparam int CW = cnt_width(BL, TDPL, TRP);

  cmd_e     cmd;
  bank_st_e st_arr [NB];
  logic     real_cmd;
  logic     cmd_ok;
  logic     rd_any;
  logic     wr_any;
  logic     burst_idle;
  logic     intr_go;
  logic [NB-1:0] wrap_vec;

  assign cmd      = cmd_e'(cmd_code);
  assign real_cmd = (cmd == CMD_ACT) || (cmd == CMD_RD) ||
                    (cmd == CMD_WR)  || (cmd == CMD_PRE);
  assign cmd_ok   = real_cmd && cmd_allowed(cmd, st_arr[cmd_bank]);
  assign rd_any   = cmd_ok && (cmd == CMD_RD);
  assign wr_any   = cmd_ok && (cmd == CMD_WR);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == b[$clog2(NB)-1:0]) && cmd_ok;

    sdram_bank_fsm #(
      .BL(BL), .TDPL(TDPL), .TRP(TRP), .CW(CW)
    ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_go    (sel && cmd == CMD_ACT),
      .rd_go     (sel && cmd == CMD_RD),
      .wr_go     (sel && cmd == CMD_WR),
      .pre_go    (sel && cmd == CMD_PRE),
      .ap        (cmd_ap),
      .burst_idle(burst_idle),
      .intr_go   (intr_go),
      .st        (st_arr[b])
    );

    assign bank_ready[b] = (st_arr[b] == BK_IDLE);
    assign bank_open[b]  = (st_arr[b] == BK_OPEN);
    assign bank_recov[b] = (st_arr[b] == BK_RECOV);
    assign bank_prech[b] = (st_arr[b] == BK_PRECH);
    assign wrap_vec[b]   = (st_arr[b] == BK_WRAP);

    // R1
    // at most one of the visible flags per bank
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bank_ready[b], bank_open[b], bank_recov[b], bank_prech[b]}));
  end

  sdram_wr_burst #(.BL(BL), .CW(CW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_any),
    .rd_go     (rd_any),
    .burst_idle(burst_idle),
    .intr_go   (intr_go),
    .wr_accept (wr_accept)
  );

  sdram_rd_pipe #(.CL(CL), .BL(BL), .CW(CW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_go   (rd_any),
    .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= real_cmd && !cmd_ok;
  end

  // R4
  // only one bank at a time can own the write data bus in an auto-precharge burst
  one_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wrap_vec) <= 1);

  // R8
  // an illegal write with no burst running produces no write beat
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR && !cmd_ok && burst_idle) |-> !wr_accept);

  // R8
  // an illegal command leaves the open flags as they were
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (real_cmd && !cmd_ok && cmd == CMD_ACT) |=> $stable(bank_open));

endmodule

// File: tb/sdram_ap_tracker_bench.sv
module sdram_ap_tracker_bench;

  localparam int NB   = 4;
  localparam int BL   = 4;
  localparam int CL   = 3;
  localparam int TDPL = 2;
  localparam int TRP  = 3;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_code = NOP;
  logic [1:0]    cmd_bank = '0;
  logic          cmd_ap = 1'b0;
  logic [NB-1:0] bank_ready, bank_open, bank_recov, bank_prech;
  logic          wr_accept, rd_valid, proto_err;
  logic          acc_now;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sdram_ap_tracker #(.NB(NB), .BL(BL), .CL(CL), .TDPL(TDPL), .TRP(TRP)) u_sdram_ap_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .bank_ready(bank_ready), .bank_open(bank_open), .bank_recov(bank_recov),
    .bank_prech(bank_prech), .wr_accept(wr_accept), .rd_valid(rd_valid),
    .proto_err(proto_err)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample the combinational beat, step one edge, return at negedge
  task automatic tick(input logic [2:0] c, input int b, input logic ap);
    cmd_code = c;
    cmd_bank = b[1:0];
    cmd_ap   = ap;
    #1 acc_now = wr_accept;
    @(posedge clk);
    @(negedge clk);
    cmd_code = NOP;
    cmd_ap   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_code = NOP;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // expected {ready, recov, prech} j edges in, recovery starting at edge rs
  function automatic int exp_after_rec(input int j, input int rs);
    if (j < rs)               return 0;
    if (j < rs + TDPL)        return 2;
    if (j < rs + TDPL + TRP)  return 1;
    return 4;
  endfunction

  // expected {ready, recov, prech} j edges in, precharge starting at edge ps
  function automatic int exp_after_pre(input int j, input int ps);
    if (j < ps)        return 0;
    if (j < ps + TRP)  return 1;
    return 4;
  endfunction

  function automatic int flags(input int b);
    return {29'd0, bank_ready[b], bank_recov[b], bank_prech[b]};
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk(bank_ready, 4'hF, "R1", "ready after reset");
    chk({bank_open, bank_recov, bank_prech}, 0, "R1", "flags after reset");
    chk({wr_accept, rd_valid, proto_err}, 0, "R1", "strobes after reset");
  endtask

  task automatic t_plain_wrap();
    do_reset();
    tick(ACT, 0, 0);
    chk(bank_open[0], 1, "R1", "ACTIVE opens bank 0");
    tick(WR, 0, 1);
    chk(acc_now, 1, "R2", "beat in command cycle");
    chk(flags(0), 0, "R6", "bank busy after edge 0");
    for (int j = 1; j <= BL + TDPL + TRP; j++) begin
      tick(NOP, 0, 0);
      if (j <= BL) chk(acc_now, (j < BL) ? 1 : 0, "R2", $sformatf("beat window cycle %0d", j));
      chk(flags(0), exp_after_rec(j, BL), "R6", $sformatf("bank 0 phase edge %0d", j));
    end
    tick(ACT, 0, 0);
    chk(bank_open[0], 1, "R9", "ACTIVE in first ready cycle accepted");
    chk(proto_err, 0, "R9", "no error on ACTIVE at ready");
  endtask

  task automatic t_read_cut();
    int k;
    do_reset();
    tick(ACT, 0, 0);
    tick(ACT, 1, 0);
    tick(WR, 0, 1);
    chk(acc_now, 1, "R2", "first beat before read cut");
    tick(NOP, 0, 0);
    chk(acc_now, 1, "R3", "beat a+1 kept");
    tick(RD, 1, 0);
    k = 2;
    chk(acc_now, 0, "R3", "no beat in READ cycle");
    chk(flags(0), exp_after_rec(k, k), "R5", "bank 0 recovery from READ edge");
    for (int j = k + 1; j <= k + CL + BL + 1; j++) begin
      tick(NOP, 0, 0);
      chk(acc_now, 0, "R3", $sformatf("no beat after cut, edge %0d", j));
      chk(flags(0), exp_after_rec(j, k), "R5", $sformatf("bank 0 phase edge %0d", j));
      chk(rd_valid, (j >= k + CL - 1 && j <= k + CL + BL - 2) ? 1 : 0, "R7",
          $sformatf("read window edge %0d", j));
    end
    chk(bank_open[1], 1, "R7", "plain READ leaves bank 1 open");
  endtask

  task automatic t_write_cut();
    int k;
    do_reset();
    tick(ACT, 0, 0);
    tick(ACT, 1, 0);
    tick(WR, 0, 1);
    tick(NOP, 0, 0);
    tick(NOP, 0, 0);
    tick(WR, 1, 0);
    k = 3;
    chk(acc_now, 1, "R4", "beat in interrupting WRITE cycle");
    chk(flags(0), exp_after_rec(k, k), "R5", "bank 0 recovery from WRITE edge");
    for (int j = k + 1; j <= k + TDPL + TRP + 1; j++) begin
      tick(NOP, 0, 0);
      if (j <= k + BL) chk(acc_now, (j < k + BL) ? 1 : 0, "R4", $sformatf("new burst beat edge %0d", j));
      chk(flags(0), exp_after_rec(j, k), "R5", $sformatf("bank 0 phase edge %0d", j));
    end
    chk(bank_open[1], 1, "R12", "write without auto precharge keeps bank open");
  endtask

  task automatic t_proto_err();
    do_reset();
    tick(RD, 2, 0);
    chk(proto_err, 1, "R8", "READ to idle bank flagged");
    chk(bank_ready[2], 1, "R8", "idle bank unchanged");
    tick(ACT, 0, 0);
    chk(proto_err, 0, "R8", "legal ACTIVE not flagged");
    tick(WR, 0, 1);
    tick(ACT, 0, 0);
    chk(acc_now, 1, "R8", "burst continues past illegal ACTIVE");
    chk(proto_err, 1, "R8", "ACTIVE during write burst flagged");
    for (int j = 2; j <= BL + TDPL + TRP; j++) begin
      tick((j == BL + 1) ? RD : NOP, 0, 0);
      if (j == BL + 1) chk(proto_err, 1, "R8", "READ during recovery flagged");
      else             chk(proto_err, 0, "R8", $sformatf("error clear edge %0d", j));
      chk(flags(0), exp_after_rec(j, BL), "R8", $sformatf("schedule kept edge %0d", j));
      chk(rd_valid, 0, "R8", $sformatf("no read data edge %0d", j));
    end
  endtask

  task automatic t_read_ap_and_pre();
    do_reset();
    tick(ACT, 0, 0);
    tick(ACT, 1, 0);
    tick(RD, 0, 1);
    tick(PRE, 1, 0);
    chk(flags(1), exp_after_pre(1, 1), "R11", "bank 1 precharging");
    for (int j = 2; j <= BL + TRP + 1; j++) begin
      tick(NOP, 0, 0);
      chk(flags(0), exp_after_pre(j, BL), "R10", $sformatf("bank 0 read-ap phase edge %0d", j));
      chk(flags(1), exp_after_pre(j, 1), "R11", $sformatf("bank 1 precharge phase edge %0d", j));
      chk(rd_valid, (j >= CL - 1 && j <= CL + BL - 2) ? 1 : 0, "R7",
          $sformatf("read-ap data window edge %0d", j));
    end
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_plain_wrap();
    t_read_cut();
    t_write_cut();
    t_proto_err();
    t_read_ap_and_pre();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule